// File: doc/BRIEF.md
# Rotating Line Store for a 4x4 Interpolator

This block is a 16 KB line store between a bus-side writer and an image interpolation engine that needs a 4x4 pixel neighbourhood. The bus side sees a 32-bit port that can read and write. Lines of RGB pixels go in through it, and the storage also works as plain memory through the same port. The interpolator sees a 128-bit read-only port that returns four adjacent pixels per access. The storage is made of eight 2 KB areas, and each area holds one line of 512 pixel slots. Those slots are 510 visible pixels plus a padding pixel at each end, and each pixel is 32 bits.

The areas form a ring. After the writer finishes a line, it pulses `line_commit`. The block then counts the line as resident, and `wr_area` moves to the next free area. Once four lines are resident, `window_ready` goes high. The interpolator addresses rows 0 to 3 of the current window, relative to `window_base`. When it has finished with the oldest row it pulses `line_done`. That frees the area and slides the window forward by one area.

Top module: `lbuf_ring`

## Requirements
- R1: After a synchronous reset, `window_ready`, `full`, `a_rvalid` and `b_rvalid` are 0, and `window_base` and `wr_area` are 0.
- R2: A Port A read (`a_en`=1, `a_we`=0) returns, one cycle later, the word last written to the same `a_addr`. `a_rvalid` is high in that cycle. Word address bits [11:9] give the area, and bits [8:0] give the pixel slot.
- R3: A Port B read returns data one cycle after `b_en`, with `b_rvalid` high. Bits [32k+31:32k] hold pixel slot 4*`b_quad`+k of the selected area, for k = 0 to 3.
- R4: `window_ready` is 1 exactly while four or more committed lines are resident. It changes in the cycle after the commit or release that crosses the threshold.
- R5: An accepted `line_commit` adds one resident line. The next cycle, `wr_area` becomes (`window_base` + resident count) mod 8.
- R6: A `line_done` pulse while `window_ready` is 1 advances `window_base` by one, modulo 8, and removes one resident line. While `window_ready` is 0, a `line_done` pulse changes nothing.
- R7: `full` is 1 while all eight areas hold resident lines. A `line_commit` while `full` is 1 is refused: the count, `wr_area` and `full` stay unchanged.
- R8: Port B reads area (`window_base` + `b_row`) mod 8. The area index wraps from 7 to 0.
- R9: If `line_commit` and `line_done` are both accepted in the same cycle, the resident count is unchanged. Both `window_base` and `wr_area` advance by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_en | input | 1 | Port A access strobe |
| a_we | input | 1 | Port A write (1) or read (0) |
| a_addr | input | 12 | Port A 32-bit word address |
| a_wdata | input | 32 | Port A write data |
| a_rvalid | output | 1 | Port A read data valid |
| a_rdata | output | 32 | Port A read data |
| line_commit | input | 1 | Pulse: a line has been written into `wr_area` |
| line_done | input | 1 | Pulse: the oldest window row is released |
| window_ready | output | 1 | Four or more lines resident |
| full | output | 1 | All eight areas resident |
| window_base | output | 3 | Area of window row 0 |
| wr_area | output | 3 | Area the next line should be written to |
| b_en | input | 1 | Port B read strobe |
| b_row | input | 2 | Window row 0 to 3 |
| b_quad | input | 7 | Group of four pixels within the row |
| b_rvalid | output | 1 | Port B read data valid |
| b_rdata | output | 128 | Four adjacent pixels |

## Verification
The assertions check the following every cycle:
- `full` is never high without `window_ready`.
- A refused commit never moves `wr_area`.
- A release slides `window_base` by exactly one, or not at all when the window is not ready.
- A lone commit advances `wr_area` by one.
- Both read ports raise their valid one cycle after a read request.

Other behaviours show up only in the bench's scenarios:
- data coming back intact through the asymmetric ports;
- the lane ordering inside the 128-bit word;
- row-to-area wrap-around;
- the exact cycles where the ready threshold is crossed;
- the simultaneous commit and release.

// File: rtl/lbuf_pkg.sv
package lbuf_pkg;
  localparam int unsigned PIX_W_D     = 32;
  localparam int unsigned LANES_D     = 4;
  localparam int unsigned AREAS_D     = 8;
  localparam int unsigned SLOTS_D     = 512;
  localparam int unsigned WIN_ROWS_D  = 4;
endpackage

// File: rtl/lbuf_lane_ram.sv
module lbuf_lane_ram #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 1024,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          a_en,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wd,
  output logic [DW-1:0] a_rd,
  input  logic          b_en,
  input  logic [AW-1:0] b_addr,
  output logic [DW-1:0] b_rd
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_en) begin
      if (a_we) mem[a_addr] <= a_wd;
      a_rd <= mem[a_addr];
    end
  end

  always_ff @(posedge clk) begin
    if (b_en) b_rd <= mem[b_addr];
  end
endmodule

// File: rtl/lbuf_ring_ctrl.sv
module lbuf_ring_ctrl #(
  parameter int unsigned AREAS    = 8,
  parameter int unsigned WIN_ROWS = 4,
  localparam int unsigned ARW     = $clog2(AREAS),
  localparam int unsigned CW      = $clog2(AREAS + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           line_commit,
  input  logic           line_done,
  output logic           window_ready,
  output logic           full,
  output logic [ARW-1:0] window_base,
  output logic [ARW-1:0] wr_area
);
  logic [CW-1:0]  count_q, count_n;
  logic [ARW-1:0] base_n;
  logic           take_commit, take_done;

  assign take_commit = line_commit && !full;
  assign take_done   = line_done && window_ready;

  always_comb begin
    count_n = count_q;
    if (take_commit && !take_done) count_n = count_q + 1'b1;
    if (take_done && !take_commit) count_n = count_q - 1'b1;
    base_n = take_done ? window_base + 1'b1 : window_base;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q      <= '0;
      window_base  <= '0;
      wr_area      <= '0;
      window_ready <= 1'b0;
      full         <= 1'b0;
    end else begin
      count_q      <= count_n;
      window_base  <= base_n;
      wr_area      <= base_n + count_n[ARW-1:0];
      window_ready <= (count_n >= CW'(WIN_ROWS));
      full         <= (count_n == CW'(AREAS));
    end
  end
endmodule

// File: rtl/lbuf_ring.sv
module lbuf_ring
  import lbuf_pkg::*;
#(
  parameter int unsigned PIX_W    = PIX_W_D,
  parameter int unsigned LANES    = LANES_D,
  parameter int unsigned AREAS    = AREAS_D,
  parameter int unsigned SLOTS    = SLOTS_D,
  parameter int unsigned WIN_ROWS = WIN_ROWS_D,
  localparam int unsigned ARW     = $clog2(AREAS),
  localparam int unsigned SW      = $clog2(SLOTS),
  localparam int unsigned AAW     = ARW + SW,
  localparam int unsigned LSW     = $clog2(LANES),
  localparam int unsigned QUADS   = SLOTS / LANES,
  localparam int unsigned QW      = $clog2(QUADS),
  localparam int unsigned RW      = $clog2(WIN_ROWS),
  localparam int unsigned LDEPTH  = AREAS * QUADS,
  localparam int unsigned LAW     = $clog2(LDEPTH)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   a_en,
  input  logic                   a_we,
  input  logic [AAW-1:0]         a_addr,
  input  logic [PIX_W-1:0]       a_wdata,
  output logic                   a_rvalid,
  output logic [PIX_W-1:0]       a_rdata,
  input  logic                   line_commit,
  input  logic                   line_done,
  output logic                   window_ready,
  output logic                   full,
  output logic [ARW-1:0]         window_base,
  output logic [ARW-1:0]         wr_area,
  input  logic                   b_en,
  input  logic [RW-1:0]          b_row,
  input  logic [QW-1:0]          b_quad,
  output logic                   b_rvalid,
  output logic [LANES*PIX_W-1:0] b_rdata
);
  logic [LSW-1:0]   a_lane, a_lane_q;
  logic [LAW-1:0]   a_row;
  logic [ARW-1:0]   b_area;
  logic [LAW-1:0]   b_addr;
  logic [PIX_W-1:0] a_rd_lane [LANES];

  assign a_lane = a_addr[LSW-1:0];
  assign a_row  = a_addr[AAW-1:LSW];
  assign b_area = window_base + ARW'(b_row);
  assign b_addr = {b_area, b_quad};

  lbuf_ring_ctrl #(.AREAS(AREAS), .WIN_ROWS(WIN_ROWS)) u_ctrl (
    .clk(clk), .rst(rst),
    .line_commit(line_commit), .line_done(line_done),
    .window_ready(window_ready), .full(full),
    .window_base(window_base), .wr_area(wr_area)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    lbuf_lane_ram #(.DW(PIX_W), .DEPTH(LDEPTH)) u_ram (
      .clk(clk),
      .a_en(a_en && (a_lane == LSW'(k))),
      .a_we(a_we),
      .a_addr(a_row),
      .a_wd(a_wdata),
      .a_rd(a_rd_lane[k]),
      .b_en(b_en),
      .b_addr(b_addr),
      .b_rd(b_rdata[k*PIX_W +: PIX_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_rvalid <= 1'b0;
      b_rvalid <= 1'b0;
      a_lane_q <= '0;
    end else begin
      a_rvalid <= a_en && !a_we;
      b_rvalid <= b_en;
      if (a_en) a_lane_q <= a_lane;
    end
  end

  assign a_rdata = a_rd_lane[a_lane_q];
endmodule

// File: rtl/lbuf_ring_chk.sv
module lbuf_ring_chk #(
  parameter int unsigned ARW = 3
) (
  input logic           clk,
  input logic           rst,
  input logic           a_en,
  input logic           a_we,
  input logic           a_rvalid,
  input logic           b_en,
  input logic           b_rvalid,
  input logic           line_commit,
  input logic           line_done,
  input logic           window_ready,
  input logic           full,
  input logic [ARW-1:0] window_base,
  input logic [ARW-1:0] wr_area
);
  p_full_has_window_r7: assert property (@(posedge clk) disable iff (rst)
    full |-> window_ready);

  p_refused_commit_r7: assert property (@(posedge clk) disable iff (rst)
    (line_commit && full) |=> $stable(wr_area));

  p_idle_release_r6: assert property (@(posedge clk) disable iff (rst)
    (line_done && !window_ready) |=> $stable(window_base));

  p_release_step_r6: assert property (@(posedge clk) disable iff (rst)
    (line_done && window_ready) |=> (window_base == $past(window_base) + 1'b1));

  p_commit_step_r5: assert property (@(posedge clk) disable iff (rst)
    (line_commit && !full && !line_done) |=> (wr_area == $past(wr_area) + 1'b1));

  p_a_read_valid_r2: assert property (@(posedge clk) disable iff (rst)
    (a_en && !a_we) |=> a_rvalid);

  p_b_read_valid_r3: assert property (@(posedge clk) disable iff (rst)
    b_en |=> b_rvalid);
endmodule

bind lbuf_ring lbuf_ring_chk #(.ARW(ARW)) u_chk (
  .clk(clk), .rst(rst), .a_en(a_en), .a_we(a_we), .a_rvalid(a_rvalid),
  .b_en(b_en), .b_rvalid(b_rvalid), .line_commit(line_commit),
  .line_done(line_done), .window_ready(window_ready), .full(full),
  .window_base(window_base), .wr_area(wr_area)
);

// File: tb/lbuf_ring_tb.sv
module lbuf_ring_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  localparam logic [43:0] VEC [NVEC] = '{
    {12'h000, 32'hDEAD0000}, {12'h001, 32'hDEAD0001}, {12'h002, 32'hC0DE0002},
    {12'h003, 32'h12345678}, {12'h7FF, 32'hA5A5A5A5}, {12'hFFF, 32'h0BADF00D}
  };

  logic clk = 0, rst = 1;
  logic a_en = 0, a_we = 0;
  logic [11:0] a_addr = '0;
  logic [31:0] a_wdata = '0;
  logic a_rvalid;
  logic [31:0] a_rdata;
  logic line_commit = 0, line_done = 0;
  logic window_ready, full;
  logic [2:0] window_base, wr_area;
  logic b_en = 0;
  logic [1:0] b_row = '0;
  logic [6:0] b_quad = '0;
  logic b_rvalid;
  logic [127:0] b_rdata;
  int checks = 0, errors = 0;
  bit done_flag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lbuf_ring u_dut (
    .clk(clk), .rst(rst), .a_en(a_en), .a_we(a_we), .a_addr(a_addr),
    .a_wdata(a_wdata), .a_rvalid(a_rvalid), .a_rdata(a_rdata),
    .line_commit(line_commit), .line_done(line_done),
    .window_ready(window_ready), .full(full), .window_base(window_base),
    .wr_area(wr_area), .b_en(b_en), .b_row(b_row), .b_quad(b_quad),
    .b_rvalid(b_rvalid), .b_rdata(b_rdata)
  );

  function automatic logic [31:0] pat(input int area, input int slot);
    return 32'h5A000000 ^ (32'(area) << 16) ^ 32'(slot);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic a_write(input logic [11:0] ad, input logic [31:0] d);
    @(negedge clk); a_en = 1; a_we = 1; a_addr = ad; a_wdata = d;
    @(posedge clk); #1; a_en = 0; a_we = 0;
  endtask

  task automatic a_read(input logic [11:0] ad, output logic [31:0] d, output logic v);
    @(negedge clk); a_en = 1; a_we = 0; a_addr = ad;
    @(posedge clk); #1; d = a_rdata; v = a_rvalid; a_en = 0;
  endtask

  task automatic b_read(input int row, input int quad, output logic [127:0] d, output logic v);
    @(negedge clk); b_en = 1; b_row = 2'(row); b_quad = 7'(quad);
    @(posedge clk); #1; d = b_rdata; v = b_rvalid; b_en = 0;
  endtask

  task automatic step(input bit c, input bit dn);
    @(negedge clk); line_commit = c; line_done = dn;
    @(posedge clk); #1; line_commit = 0; line_done = 0;
  endtask

  function automatic logic [127:0] quad_exp(input int area, input int quad);
    logic [127:0] r;
    for (int k = 0; k < 4; k++) r[k*32 +: 32] = pat(area, quad*4 + k);
    return r;
  endfunction

  task automatic check_b(input int row, input int quad, input int area, input string tag);
    logic [127:0] d; logic v;
    b_read(row, quad, d, v);
    check(v === 1'b1, tag, 128'(v), 128'd1);
    check(d === quad_exp(area, quad), tag, d, quad_exp(area, quad));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d; logic v;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check({window_ready, full, a_rvalid, b_rvalid} === 4'b0, "R1 flags", 128'({window_ready, full, a_rvalid, b_rvalid}), 0);
    check({window_base, wr_area} === 6'b0, "R1 pointers", 128'({window_base, wr_area}), 0);
    @(negedge clk); rst = 0;

    // R2 vector table: write all, then read back
    for (int i = 0; i < NVEC; i++) a_write(VEC[i][43:32], VEC[i][31:0]);
    for (int i = 0; i < NVEC; i++) begin
      a_read(VEC[i][43:32], d, v);
      check(v === 1'b1, "R2 rvalid", 128'(v), 1);
      check(d === VEC[i][31:0], "R2 readback", 128'(d), 128'(VEC[i][31:0]));
    end

    // fill every area with a known pattern (area in [11:9], slot in [8:0])
    for (int ar = 0; ar < 8; ar++)
      for (int s = 0; s < 512; s++) a_write(12'((ar << 9) | s), pat(ar, s));
    a_read(12'h5FE, d, v);
    check(d === pat(2, 510), "R2 area slot", 128'(d), 128'(pat(2, 510)));

    // R5 / R4: three commits, not yet ready
    for (int i = 0; i < 3; i++) step(1, 0);
    check(wr_area === 3'd3, "R5 wr_area after 3", 128'(wr_area), 3);
    check(window_ready === 1'b0, "R4 not ready at 3", 128'(window_ready), 0);
    // R6 release ignored when not ready
    step(0, 1);
    check(window_base === 3'd0, "R6 idle release", 128'(window_base), 0);
    check(wr_area === 3'd3, "R6 idle release count", 128'(wr_area), 3);
    step(1, 0);
    check(window_ready === 1'b1, "R4 ready at 4", 128'(window_ready), 1);

    // R3 lane order, R8 row mapping
    check_b(2, 5, 2, "R3 quad lanes");
    check_b(0, 127, 0, "R3 last quad");

    step(0, 1);
    check(window_base === 3'd1, "R6 release advances", 128'(window_base), 1);
    check(window_ready === 1'b0, "R4 drop below 4", 128'(window_ready), 0);
    check_b(3, 9, 4, "R8 row offset");

    // R7 fill to eight
    for (int i = 0; i < 5; i++) step(1, 0);
    check(full === 1'b1, "R7 full at 8", 128'(full), 1);
    check(wr_area === 3'd1, "R5 wr_area wrap", 128'(wr_area), 1);
    step(1, 0);
    check(wr_area === 3'd1 && full === 1'b1, "R7 refused commit", 128'({full, wr_area}), 128'({1'b1, 3'd1}));

    // release down to three lines: base 6
    for (int i = 0; i < 5; i++) step(0, 1);
    check(window_base === 3'd6, "R6 base after 5 releases", 128'(window_base), 6);
    check(full === 1'b0 && window_ready === 1'b0, "R4 count 3", 128'({full, window_ready}), 0);
    step(0, 1);
    check(window_base === 3'd6, "R6 ignored at 3", 128'(window_base), 6);
    check_b(3, 64, 1, "R8 wrap 6+3");

    // R9 simultaneous commit and release
    step(1, 0);
    check(wr_area === 3'd2 && window_ready === 1'b1, "R9 setup", 128'({window_ready, wr_area}), 128'({1'b1, 3'd2}));
    step(1, 1);
    check(window_base === 3'd7, "R9 base", 128'(window_base), 7);
    check(wr_area === 3'd3, "R9 wr_area", 128'(wr_area), 3);
    check(window_ready === 1'b1, "R9 count kept", 128'(window_ready), 1);

    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule